// File: doc/BRIEF.md
# Receive Descriptor Ring Closer

This block steps through a circular table of receive descriptors kept in a small descriptor store inside the block. Each descriptor is one 64-bit word with three fields: a status word, a length and a buffer pointer. Software prepares a descriptor through the host port and hands it over by setting its ownership bit. The block then fetches it and checks that the buffer pointer is aligned for the current timestamp mode. After that it counts frame octets that arrive on a valid/ready byte stream. Only the count and the end-of-frame marker are modelled; no data is stored.

A buffer is closed when it has taken the configured maximum number of octets, or when the frame ends. Closing writes the length and status back into the store and returns ownership to software. A buffer that is not the frame's final one records its own octet count. The final buffer records the whole frame length plus the CRC octets. Closing also moves the ring index forward, or back to entry 0 if the wrap bit is set. A misaligned descriptor is returned at once with an error flag and receives no octets. If the next descriptor still belongs to software, input stalls.

Top module: `rxdesc_ring_closer`

## Requirements
- R1: After reset the ring index is 0, every stored word reads 0, `in_ready` is 0 and `busy` is 0.
- R2: Each store word is laid out as status in bits [63:48], length in bits [47:32] and pointer in bits [31:0]. The status bits are: 15 = owned by block, 13 = wrap, 11 = last in frame, 10 = first in frame, 1 = alignment error. A host write lands on the next clock edge, and `host_rdata` shows the word at `host_idx` combinationally.
- R3: `in_ready` is 1 only while a fetched, aligned, block-owned descriptor is current. An octet is taken on a clock edge with `in_valid` and `in_ready` both 1.
- R4: When an octet that is not the frame's final one brings the buffer count to `cfg_max_len`, that buffer closes with length `cfg_max_len` and the last bit at 0.
- R5: The octet carrying `in_last` closes the buffer with the last bit at 1. Its length is the frame's total octet count plus 2 (`cfg_crc32`=0) or plus 4 (`cfg_crc32`=1). This holds even when that octet exactly fills the buffer, and `cfg_ts` adds nothing to any length.
- R6: The first bit is 1 on the first buffer of each frame and 0 on every later buffer of that frame.
- R7: A closed word has the ownership bit cleared, the wrap bit kept, the last, first and error bits set as the close decides, all other status bits at 0 and the pointer unchanged. `closed_o` is high for one cycle per close.
- R8: With `cfg_ts`=0 the pointer must be a nonzero multiple of 8; with `cfg_ts`=1 the pointer's low three bits must be 100. A descriptor failing this is closed with the error bit set, length 0 and first and last bits at 0, takes no octets, and `align_err` is high in its close cycle.
- R9: After a close, the index goes to 0 if the closed descriptor had its wrap bit set, otherwise to the next entry, and from the top entry back to 0. The index changes at no other time.
- R10: While the current descriptor is still owned by software, `in_ready` stays 0 and `busy` equals `in_valid`. Input resumes once software hands that descriptor over.
- R11: A closing octet accepted in one cycle makes `closed_o` high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_max_len | input | 16 | Maximum octets per buffer (at least 1) |
| cfg_crc32 | input | 1 | CRC size added to frame length: 0 = 2 octets, 1 = 4 octets |
| cfg_ts | input | 1 | Timestamp mode, selects the pointer alignment rule |
| in_valid | input | 1 | An octet is offered |
| in_last | input | 1 | The offered octet ends the frame |
| in_ready | output | 1 | An octet can be taken this cycle |
| busy | output | 1 | Input stalled on a descriptor still owned by software |
| host_we | input | 1 | Host write strobe |
| host_idx | input | $clog2(RING_DEPTH) | Ring entry for host read and write |
| host_wdata | input | 64 | Descriptor word to write |
| host_rdata | output | 64 | Descriptor word at host_idx |
| closed_o | output | 1 | A descriptor is written back this cycle |
| align_err | output | 1 | The descriptor closed this cycle failed the alignment check |

## Verification
The bench builds the block with the default eight-entry ring. With that size, frames of up to four buffers plus a few misaligned entries fit in one pass, and the wrap bit on the top entry is crossed many times. The maximum buffer length is varied between 3 and 10 octets, so buffers close both on a full count and on an exact fill that coincides with the end of a frame. Switching the timestamp mode while the ring is full makes every pending descriptor fail alignment in turn, which exercises the error-close chain until the block stalls on a closed entry.

// File: rtl/rxr_pkg.sv
// Package for the receive descriptor ring closer.
// Holds the descriptor word layout, the status bit positions and the
// controller state encoding. Assumes a 64-bit descriptor word.
package rxr_pkg;

    localparam int LEN_W = 16;
    localparam int PTR_W = 32;
    localparam int STS_W = 16;

    // status bit positions inside the 16-bit status field
    localparam int SB_OWN   = 15;
    localparam int SB_WRAP  = 13;
    localparam int SB_LAST  = 11;
    localparam int SB_FIRST = 10;
    localparam int SB_AERR  = 1;

    typedef struct packed {
        logic [STS_W-1:0] status;
        logic [LEN_W-1:0] len;
        logic [PTR_W-1:0] ptr;
    } rxr_desc_t;

    localparam int DESC_W = $bits(rxr_desc_t);

    typedef enum logic [1:0] {
        S_FETCH = 2'd0,
        S_RECV  = 2'd1,
        S_CLOSE = 2'd2
    } rxr_state_e;

endpackage

// File: rtl/rxr_desc_mem.sv
// Descriptor store: RING_DEPTH words of rxr_desc_t.
// Two write ports (host and closer) and two read ports. When both ports
// write the same entry in one cycle the closer's write is kept.
// Assumes the closer index is always below RING_DEPTH.
module rxr_desc_mem
    import rxr_pkg::*;
#(
    parameter int RING_DEPTH = 8,
    parameter int IDX_W      = $clog2(RING_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_idx,
    input  rxr_desc_t         host_wdata,
    output rxr_desc_t         host_rdata,
    input  logic              blk_we,
    input  logic [IDX_W-1:0]  blk_idx,
    input  rxr_desc_t         blk_wdata,
    output logic              blk_own,
    output logic              blk_wrap,
    output logic [PTR_W-1:0]  blk_ptr
);

    rxr_desc_t ent [RING_DEPTH];

    // Entry update: closer write has priority over host write.
    always_ff @(posedge clk) begin
        for (int i = 0; i < RING_DEPTH; i++) begin
            if (!rst_n) begin
                ent[i] <= '0;
            end else if (blk_we && (int'(blk_idx) == i)) begin
                ent[i] <= blk_wdata;
            end else if (host_we && (int'(host_idx) == i)) begin
                ent[i] <= host_wdata;
            end
        end
    end

    // Host read: out-of-range index reads as zero.
    always_comb begin
        host_rdata = '0;
        if (int'(host_idx) < RING_DEPTH) begin
            host_rdata = ent[host_idx];
        end
    end

    // Closer read: only the fields the controller consumes.
    always_comb begin
        blk_own  = ent[blk_idx].status[SB_OWN];
        blk_wrap = ent[blk_idx].status[SB_WRAP];
        blk_ptr  = ent[blk_idx].ptr;
    end

endmodule

// File: rtl/rxr_align_chk.sv
// Buffer pointer alignment check.
// Timestamp mode off: pointer must be a nonzero multiple of 8.
// Timestamp mode on:  pointer must be 4 below a multiple of 8 (low bits 100).
// Purely combinational.
module rxr_align_chk
    import rxr_pkg::*;
(
    input  logic [PTR_W-1:0] ptr,
    input  logic             ts_mode,
    output logic             ptr_ok
);

    // Select the rule for the current timestamp mode.
    always_comb begin
        if (ts_mode) begin
            ptr_ok = (ptr[2:0] == 3'b100);
        end else begin
            ptr_ok = (ptr[2:0] == 3'b000) && (ptr != '0);
        end
    end

endmodule

// File: rtl/rxr_octet_cnt.sv
// Octet counters: octets in the current buffer and octets in the current
// frame. The *_next outputs give the count including the octet being taken
// this cycle. Clears take priority; they never coincide with an accept.
module rxr_octet_cnt
    import rxr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             clr_buf,
    input  logic             clr_frm,
    output logic [LEN_W-1:0] buf_next,
    output logic [LEN_W-1:0] frm_next
);

    logic [LEN_W-1:0] buf_cnt;
    logic [LEN_W-1:0] frm_cnt;

    // Incremented counts for the octet on offer.
    always_comb begin
        buf_next = buf_cnt + 1'b1;
        frm_next = frm_cnt + 1'b1;
    end

    // Buffer counter: zeroed whenever a descriptor closes.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_buf) begin
            buf_cnt <= '0;
        end else if (accept) begin
            buf_cnt <= buf_next;
        end
    end

    // Frame counter: zeroed when the frame's final buffer closes.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_frm) begin
            frm_cnt <= '0;
        end else if (accept) begin
            frm_cnt <= frm_next;
        end
    end

endmodule

// File: rtl/rxr_ring_ctrl.sv
// Ring controller: fetch, receive, close.
// FETCH waits for a block-owned descriptor and checks its pointer.
// RECV takes octets until the buffer fills or the frame ends.
// CLOSE writes the word back (one cycle) and advances the ring index.
// Assumes cfg_max_len >= 1 and that the store read is combinational.
module rxr_ring_ctrl
    import rxr_pkg::*;
#(
    parameter int RING_DEPTH = 8,
    parameter int IDX_W      = $clog2(RING_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cur_own,
    input  logic              cur_wrap,
    input  logic [PTR_W-1:0]  cur_ptr,
    input  logic              ptr_ok,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [LEN_W-1:0]  cfg_max_len,
    input  logic              cfg_crc32,
    input  logic [LEN_W-1:0]  buf_next,
    input  logic [LEN_W-1:0]  frm_next,
    output logic [IDX_W-1:0]  cur_idx,
    output logic              wrap_q,
    output logic              in_ready,
    output logic              busy,
    output logic              accept,
    output logic              clr_buf,
    output logic              clr_frm,
    output logic              blk_we,
    output rxr_desc_t         blk_wdata,
    output logic              closed_o,
    output logic              align_err
);

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RING_DEPTH - 1);

    rxr_state_e       state;
    logic [PTR_W-1:0] ptr_q;
    logic [LEN_W-1:0] len_q;
    logic             last_q;
    logic             aerr_q;
    logic             first_q;
    logic [LEN_W-1:0] crc_add;
    logic [IDX_W-1:0] next_idx;
    logic             buf_full;

    // CRC octets added to the final buffer's length.
    always_comb begin
        crc_add  = cfg_crc32 ? LEN_W'(4) : LEN_W'(2);
        buf_full = (buf_next == cfg_max_len);
    end

    // Next ring position after a close.
    always_comb begin
        if (wrap_q || (cur_idx == TOP_IDX)) begin
            next_idx = '0;
        end else begin
            next_idx = cur_idx + 1'b1;
        end
    end

    // Handshake and event outputs decoded from the state.
    always_comb begin
        in_ready  = (state == S_RECV);
        accept    = in_ready && in_valid;
        busy      = (state == S_FETCH) && !cur_own && in_valid;
        closed_o  = (state == S_CLOSE);
        align_err = closed_o && aerr_q;
        blk_we    = closed_o;
        clr_buf   = closed_o;
        clr_frm   = closed_o && last_q;
    end

    // Write-back word assembled from the captured close decision.
    always_comb begin
        blk_wdata                  = '0;
        blk_wdata.status[SB_WRAP]  = wrap_q;
        blk_wdata.status[SB_LAST]  = last_q;
        blk_wdata.status[SB_FIRST] = first_q && !aerr_q;
        blk_wdata.status[SB_AERR]  = aerr_q;
        blk_wdata.len              = len_q;
        blk_wdata.ptr              = ptr_q;
    end

    // Sequencer: fetch/check, receive/count, close/advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_FETCH;
            cur_idx <= '0;
            wrap_q  <= 1'b0;
            ptr_q   <= '0;
            len_q   <= '0;
            last_q  <= 1'b0;
            aerr_q  <= 1'b0;
            first_q <= 1'b1;
        end else begin
            case (state)
                S_FETCH: begin
                    if (cur_own) begin
                        wrap_q <= cur_wrap;
                        ptr_q  <= cur_ptr;
                        if (ptr_ok) begin
                            state <= S_RECV;
                        end else begin
                            aerr_q <= 1'b1;
                            len_q  <= '0;
                            last_q <= 1'b0;
                            state  <= S_CLOSE;
                        end
                    end
                end
                S_RECV: begin
                    if (accept) begin
                        if (in_last) begin
                            len_q  <= frm_next + crc_add;
                            last_q <= 1'b1;
                            state  <= S_CLOSE;
                        end else if (buf_full) begin
                            len_q  <= buf_next;
                            last_q <= 1'b0;
                            state  <= S_CLOSE;
                        end
                    end
                end
                S_CLOSE: begin
                    cur_idx <= next_idx;
                    if (!aerr_q) begin
                        first_q <= last_q;
                    end
                    aerr_q <= 1'b0;
                    state  <= S_FETCH;
                end
                default: state <= S_FETCH;
            endcase
        end
    end

endmodule

// File: rtl/rxdesc_ring_closer.sv
// Top: receive descriptor ring closer.
// Ties the descriptor store, alignment check, octet counters and ring
// controller together. Configuration inputs are expected to stay steady
// while a buffer is being filled.
module rxdesc_ring_closer
    import rxr_pkg::*;
#(
    parameter int RING_DEPTH = 8,
    localparam int IDX_W     = $clog2(RING_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cfg_max_len,
    input  logic              cfg_crc32,
    input  logic              cfg_ts,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic              busy,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic [63:0]       host_wdata,
    output logic [63:0]       host_rdata,
    output logic              closed_o,
    output logic              align_err
);

    logic [IDX_W-1:0] cur_idx;
    logic             wrap_q;
    logic             cur_own;
    logic             cur_wrap;
    logic [PTR_W-1:0] cur_ptr;
    logic             ptr_ok;
    logic             accept;
    logic             clr_buf;
    logic             clr_frm;
    logic [LEN_W-1:0] buf_next;
    logic [LEN_W-1:0] frm_next;
    logic             blk_we;
    rxr_desc_t        blk_wdata;
    rxr_desc_t        host_rd_s;

    assign host_rdata = host_rd_s;

    rxr_desc_mem #(.RING_DEPTH(RING_DEPTH), .IDX_W(IDX_W)) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_idx   (host_idx),
        .host_wdata (rxr_desc_t'(host_wdata)),
        .host_rdata (host_rd_s),
        .blk_we     (blk_we),
        .blk_idx    (cur_idx),
        .blk_wdata  (blk_wdata),
        .blk_own    (cur_own),
        .blk_wrap   (cur_wrap),
        .blk_ptr    (cur_ptr)
    );

    rxr_align_chk u_align (
        .ptr     (cur_ptr),
        .ts_mode (cfg_ts),
        .ptr_ok  (ptr_ok)
    );

    rxr_octet_cnt u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .clr_buf  (clr_buf),
        .clr_frm  (clr_frm),
        .buf_next (buf_next),
        .frm_next (frm_next)
    );

    rxr_ring_ctrl #(.RING_DEPTH(RING_DEPTH), .IDX_W(IDX_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cur_own     (cur_own),
        .cur_wrap    (cur_wrap),
        .cur_ptr     (cur_ptr),
        .ptr_ok      (ptr_ok),
        .in_valid    (in_valid),
        .in_last     (in_last),
        .cfg_max_len (cfg_max_len),
        .cfg_crc32   (cfg_crc32),
        .buf_next    (buf_next),
        .frm_next    (frm_next),
        .cur_idx     (cur_idx),
        .wrap_q      (wrap_q),
        .in_ready    (in_ready),
        .busy        (busy),
        .accept      (accept),
        .clr_buf     (clr_buf),
        .clr_frm     (clr_frm),
        .blk_we      (blk_we),
        .blk_wdata   (blk_wdata),
        .closed_o    (closed_o),
        .align_err   (align_err)
    );

endmodule

// File: rtl/rxr_closer_chk.sv
// Checker for rxdesc_ring_closer, attached with bind below.
// Relates the handshake, close events and ring index over time.
module rxr_closer_chk #(
    parameter int RING_DEPTH = 8,
    localparam int IDX_W     = $clog2(RING_DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_last,
    input logic             in_ready,
    input logic             busy,
    input logic             closed_o,
    input logic             align_err,
    input logic [IDX_W-1:0] cur_idx,
    input logic             wrap_q,
    input logic [15:0]      buf_next,
    input logic [15:0]      cfg_max_len
);

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RING_DEPTH - 1);

    // R10: a stall never coincides with accepting input
    p_stall_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_ready);

    // R11: the frame's final octet is followed by a close
    p_last_closes_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> closed_o);

    // R4: a filling octet is followed by a close
    p_full_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_last && (buf_next == cfg_max_len)) |=> closed_o);

    // R7: each close lasts a single cycle
    p_close_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        closed_o |=> !closed_o);

    // R8: alignment error only flagged on a close
    p_aerr_on_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> closed_o);

    // R9: wrap bit returns the index to entry 0
    p_wrap_to_base_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (closed_o && wrap_q) |=> (cur_idx == '0));

    // R9: without wrap the index steps by one below the top entry
    p_step_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (closed_o && !wrap_q && (cur_idx != TOP_IDX)) |=> (cur_idx == $past(cur_idx) + 1'b1));

    // R9: the index only moves on a close
    p_idx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !closed_o |=> $stable(cur_idx));

endmodule

bind rxdesc_ring_closer rxr_closer_chk #(.RING_DEPTH(RING_DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_last     (in_last),
    .in_ready    (in_ready),
    .busy        (busy),
    .closed_o    (closed_o),
    .align_err   (align_err),
    .cur_idx     (cur_idx),
    .wrap_q      (wrap_q),
    .buf_next    (buf_next),
    .cfg_max_len (cfg_max_len)
);

// File: tb/rxdesc_ring_closer_tb_top.sv
// Bench for rxdesc_ring_closer: directed corners, then seeded random frames.
// A bench model of the ring predicts every descriptor word and event count.
module rxdesc_ring_closer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int IW         = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   cfg_max_len = 16'd8;
    logic          cfg_crc32 = 1'b0;
    logic          cfg_ts = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_last = 1'b0;
    logic          in_ready;
    logic          busy;
    logic          host_we = 1'b0;
    logic [IW-1:0] host_idx = '0;
    logic [63:0]   host_wdata = '0;
    logic [63:0]   host_rdata;
    logic          closed_o;
    logic          align_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxdesc_ring_closer #(.RING_DEPTH(DEPTH)) dut_i (
        .clk (clk), .rst_n (rst_n),
        .cfg_max_len (cfg_max_len), .cfg_crc32 (cfg_crc32), .cfg_ts (cfg_ts),
        .in_valid (in_valid), .in_last (in_last), .in_ready (in_ready), .busy (busy),
        .host_we (host_we), .host_idx (host_idx), .host_wdata (host_wdata),
        .host_rdata (host_rdata), .closed_o (closed_o), .align_err (align_err)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // event monitors (read pre-edge values)
    int mon_closed = 0;
    int mon_ae     = 0;
    always @(posedge clk) begin
        if (rst_n) begin
            if (closed_o)  mon_closed++;
            if (align_err) mon_ae++;
        end
    end

    // model state
    logic [63:0] exp_mem [DEPTH];
    int m_idx = 0;
    bit m_first = 1;
    int exp_closed = 0;
    int exp_ae = 0;

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    function automatic bit aligned_f(logic [31:0] p, bit ts);
        if (ts) return p[2:0] == 3'b100;
        return (p[2:0] == 3'b000) && (p != 0);
    endfunction

    function automatic logic [63:0] mk_closed(logic [63:0] old, bit l, bit f, bit ae, logic [15:0] len);
        logic [15:0] s = '0;
        s[13] = old[61];
        s[11] = l;
        s[10] = f;
        s[1]  = ae;
        return {s, len, old[31:0]};
    endfunction

    task automatic m_adv(bit w);
        m_idx = (w || m_idx == DEPTH-1) ? 0 : m_idx + 1;
    endtask

    // misaligned owned descriptors are returned as soon as they are current
    task automatic m_skip();
        for (int k = 0; k <= DEPTH; k++) begin
            if (exp_mem[m_idx][63] && !aligned_f(exp_mem[m_idx][31:0], cfg_ts)) begin
                bit w = exp_mem[m_idx][61];
                exp_mem[m_idx] = mk_closed(exp_mem[m_idx], 0, 0, 1, 16'd0);
                exp_closed++;
                exp_ae++;
                m_adv(w);
            end else begin
                break;
            end
        end
    endtask

    task automatic m_frame(int n);
        int sent = 0;
        while (sent < n) begin
            int take = (n - sent < int'(cfg_max_len)) ? n - sent : int'(cfg_max_len);
            bit w = exp_mem[m_idx][61];
            sent += take;
            if (sent == n) begin
                exp_mem[m_idx] = mk_closed(exp_mem[m_idx], 1, m_first, 0,
                                           16'(n + (cfg_crc32 ? 4 : 2)));
                m_first = 1;
            end else begin
                exp_mem[m_idx] = mk_closed(exp_mem[m_idx], 0, m_first, 0, cfg_max_len);
                m_first = 0;
            end
            exp_closed++;
            m_adv(w);
            m_skip();
        end
    endtask

    task automatic host_put(int idx, logic [15:0] st, logic [31:0] p);
        @(negedge clk);
        host_we    = 1'b1;
        host_idx   = IW'(idx);
        host_wdata = {st, 16'd0, p};
        @(posedge clk);
        @(negedge clk);
        host_we = 1'b0;
        exp_mem[idx] = {st, 16'd0, p};
        m_skip();
    endtask

    function automatic logic [15:0] own_st(int idx);
        return (idx == DEPTH-1) ? 16'hA000 : 16'h8000;
    endfunction

    task automatic send_frame(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_last  = (i == n-1);
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        m_frame(n);
    endtask

    task automatic compare_all(string req);
        repeat (30) @(negedge clk);
        for (int i = 0; i < DEPTH; i++) begin
            host_idx = IW'(i);
            #1;
            check(host_rdata == exp_mem[i], req, $sformatf("word %0d", i), host_rdata, exp_mem[i]);
        end
        check(mon_closed == exp_closed, "R7", "close count", 64'(mon_closed), 64'(exp_closed));
        check(mon_ae == exp_ae, "R8", "align error count", 64'(mon_ae), 64'(exp_ae));
    endtask

    task automatic refill(bit allow_bad);
        bit used = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!exp_mem[i][63]) begin
                logic [31:0] p = 32'(($urandom % 1000 + 1) * 8);
                if (cfg_ts) p = p - 32'd4;
                if (allow_bad && !used && ($urandom % 6 == 0)) begin
                    p = p + 32'd2;
                    used = 1;
                end
                host_put(i, own_st(i), p);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(in_ready == 1'b0, "R1", "in_ready", 64'(in_ready), 0);
        check(busy == 1'b0, "R1", "busy", 64'(busy), 0);
        compare_all("R1");

        // R10: stall with input pending and ring owned by software
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        check(busy == 1'b1, "R10", "busy while stalled", 64'(busy), 1);
        check(in_ready == 1'b0, "R10", "ready while stalled", 64'(in_ready), 0);
        host_put(0, 16'h8000, 32'h100);
        check(busy == 1'b0, "R10", "busy after handover", 64'(busy), 0);
        // R2 R3 R5: short frame into entry 0, CRC 2
        send_frame(3);
        compare_all("R5");
        refill(0);

        // R5: exact fill of one buffer ends the frame
        cfg_max_len = 16'd8; cfg_crc32 = 1'b0;
        send_frame(8);
        compare_all("R5");
        refill(0);

        // R4 R5 R6: one octet over the limit, CRC 4
        cfg_crc32 = 1'b1;
        send_frame(9);
        compare_all("R4");
        refill(0);

        // R6: three buffers, middle one neither first nor last
        cfg_max_len = 16'd4; cfg_crc32 = 1'b0;
        send_frame(10);
        compare_all("R6");
        refill(0);

        // R8: zero pointer and a 4-offset pointer rejected with timestamp off
        repeat (5) @(negedge clk);
        host_put((m_idx + 1) % DEPTH, own_st((m_idx + 1) % DEPTH), 32'h0);
        host_put((m_idx + 2) % DEPTH, own_st((m_idx + 2) % DEPTH), 32'h204);
        send_frame(6);
        compare_all("R8");
        refill(0);

        // R8: timestamp on makes multiple-of-8 pointers fail
        repeat (5) @(negedge clk);
        cfg_ts = 1'b1;
        send_frame(1);
        compare_all("R8");
        refill(0);

        // R9 R3: random frames across many wraps
        for (int it = 0; it < 40; it++) begin
            cfg_max_len = 16'(3 + $urandom % 8);
            cfg_crc32   = 1'($urandom % 2);
            send_frame(1 + int'($urandom % (4 * int'(cfg_max_len))));
            compare_all("R9");
            refill(1);
        end

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule